// File: doc/BRIEF.md
# Disk Channel Interrupt Register Bank

This block holds the interrupt state of a single disk channel. Two event sources are latched into a two-bit status word: one reports that a transfer finished, and one reports a memory or bus error during a DMA transfer. An enable mask gates the latched bits onto one interrupt line. When an error is first latched, the failing bus address is captured into two read-only words. Software reads and writes the bank through a word-indexed register port.

Software can clear status bits in two ways. It can write ones to the status word. It can also read the device status byte: when the status-path logic reports such a read, and the byte it returns has any of the bits in mask 0x51 set, both status bits clear as a side effect. When an event arrives in the same cycle as a clear, the event wins.

A small two-state controller (`CAP_OPEN`, `CAP_HELD`) manages the error address capture. The controller starts in `CAP_OPEN`. On an error event it loads the address and moves to `CAP_HELD` (transition *capture*). It returns to `CAP_OPEN` when the error bit is cleared with no new error in the same cycle (transition *release*). In every other case it stays in its current state (transitions *wait* and *hold*).

Top module: `irq_bank`

## Requirements
- R1: After reset, the status word, the enable mask and both error address words read as 0, and `irq_o` is low.
- R2: A `done_i` pulse sets status bit 0, and a `bus_err_i` pulse sets status bit 1. Each bit stays set until it is cleared. The status word is read at word index 3, in bits 1:0.
- R3: A write to word index 3 clears each status bit whose write-data bit (bits 1:0) is 1. Bits written as 0 are unchanged.
- R4: A write to word index 5 sets each enable bit whose write-data bit is 1. A write to word index 7 clears each enable bit whose write-data bit is 1. Bits written as 0 have no effect. Reads of index 5 and of index 7 both return the enable mask in bits 1:0.
- R5: `irq_o` is high exactly when some status bit is set and its enable bit is also set.
- R6: On an error event that arrives while status bit 1 is clear, the error address is captured. Its low 32 bits read at word index 0 and its high 32 bits read at word index 1.
- R7: An error event that arrives while status bit 1 is set does not change the captured address.
- R8: A device status read (`dev_stat_rd_i`) whose byte has any of bits 0x51 set clears both status bits. With none of those bits set, the read has no effect.
- R9: An event that arrives in the same cycle as a clear (from a write or from a device status read) leaves its status bit set.
- R10: Reads of word indices 2, 4 and 6 return 0, and writes to those indices change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_idx_i | input | 3 | Word index for both reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data (combinational from the index) |
| done_i | input | 1 | Transfer-complete event pulse |
| bus_err_i | input | 1 | Bus or memory error event pulse |
| bus_err_addr_i | input | 64 | Failing address, valid while `bus_err_i` is high |
| dev_stat_rd_i | input | 1 | Device status byte read strobe |
| dev_stat_val_i | input | 8 | Device status byte value at that read |
| irq_o | output | 1 | Interrupt output |

## Verification
An event can arrive in the same cycle as a clear of its own status bit, whether the clear comes from a write-one-to-clear or from the side effect of a device status read. The bench drives both on one clock edge. It then reads the status word to check that the event's bit stayed set while the other bits cleared. The same collision is also applied while an error address is held. A following read of the address words must show that the held address was neither reloaded nor released.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned IDX_W  = 3;
    localparam int unsigned NSRC   = 2;

    localparam logic [IDX_W-1:0] IDX_EADDR_LO = 3'd0;
    localparam logic [IDX_W-1:0] IDX_EADDR_HI = 3'd1;
    localparam logic [IDX_W-1:0] IDX_STATUS   = 3'd3;
    localparam logic [IDX_W-1:0] IDX_EN_SET   = 3'd5;
    localparam logic [IDX_W-1:0] IDX_EN_CLR   = 3'd7;

    localparam int unsigned SRC_DONE = 0;
    localparam int unsigned SRC_ERR  = 1;

    localparam logic [7:0] DEV_IDLE_MASK = 8'h51;

    typedef enum logic {
        CAP_OPEN = 1'b0,
        CAP_HELD = 1'b1
    } cap_state_e;
endpackage

// File: rtl/irq_bit_latch.sv
module irq_bit_latch #(
    parameter int unsigned N = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)          q_o[g] <= 1'b0;
            else if (set_i[g])    q_o[g] <= 1'b1;
            else if (clr_i[g])    q_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_err_capture.sv
module irq_err_capture
    import irq_bank_pkg::*;
#(
    parameter int unsigned AW = 2 * WORD_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          err_i,
    input  logic [AW-1:0] err_addr_i,
    input  logic          err_clr_i,
    output logic          held_o,
    output logic [AW-1:0] addr_o
);
    cap_state_e state_q, state_d;
    logic       load;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= CAP_OPEN;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            CAP_OPEN: if (err_i) begin
                state_d = CAP_HELD;
                load    = 1'b1;
            end
            CAP_HELD: if (err_clr_i && !err_i) state_d = CAP_OPEN;
            default:  state_d = CAP_OPEN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   addr_o <= '0;
        else if (load) addr_o <= err_addr_i;
    end

    assign held_o = (state_q == CAP_HELD);
endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import irq_bank_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic [IDX_W-1:0]  reg_idx_i,
    input  logic [WORD_W-1:0] reg_wdata_i,
    output logic [WORD_W-1:0] reg_rdata_o,
    input  logic              done_i,
    input  logic              bus_err_i,
    input  logic [2*WORD_W-1:0] bus_err_addr_i,
    input  logic              dev_stat_rd_i,
    input  logic [7:0]        dev_stat_val_i,
    output logic              irq_o
);
    logic [NSRC-1:0]     status_q, enable_q;
    logic [NSRC-1:0]     evt, st_clr, en_set, en_clr;
    logic [NSRC-1:0]     w1c, auto_clr;
    logic                cap_held;
    logic [2*WORD_W-1:0] err_addr_q;

    assign evt[SRC_DONE] = done_i;
    assign evt[SRC_ERR]  = bus_err_i;

    assign w1c      = (reg_wr_i && reg_idx_i == IDX_STATUS) ? reg_wdata_i[NSRC-1:0] : '0;
    assign auto_clr = (dev_stat_rd_i && |(dev_stat_val_i & DEV_IDLE_MASK)) ? '1 : '0;
    assign st_clr   = w1c | auto_clr;
    assign en_set   = (reg_wr_i && reg_idx_i == IDX_EN_SET) ? reg_wdata_i[NSRC-1:0] : '0;
    assign en_clr   = (reg_wr_i && reg_idx_i == IDX_EN_CLR) ? reg_wdata_i[NSRC-1:0] : '0;

    irq_bit_latch #(.N(NSRC)) u_status (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(evt), .clr_i(st_clr), .q_o(status_q)
    );

    irq_bit_latch #(.N(NSRC)) u_enable (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(en_set), .clr_i(en_clr), .q_o(enable_q)
    );

    irq_err_capture #(.AW(2*WORD_W)) u_cap (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .err_i(bus_err_i), .err_addr_i(bus_err_addr_i),
        .err_clr_i(st_clr[SRC_ERR]),
        .held_o(cap_held), .addr_o(err_addr_q)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (reg_idx_i)
            IDX_EADDR_LO: reg_rdata_o = err_addr_q[WORD_W-1:0];
            IDX_EADDR_HI: reg_rdata_o = err_addr_q[2*WORD_W-1:WORD_W];
            IDX_STATUS:   reg_rdata_o[NSRC-1:0] = status_q;
            IDX_EN_SET,
            IDX_EN_CLR:   reg_rdata_o[NSRC-1:0] = enable_q;
            default:      reg_rdata_o = '0;
        endcase
    end

    assign irq_o = |(status_q & enable_q);
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        done,
    input logic        err,
    input logic        srd,
    input logic [7:0]  sval,
    input logic [1:0]  status,
    input logic [1:0]  enable,
    input logic        held,
    input logic [63:0] eaddr,
    input logic        irq
);
    p_done_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> status[0]);
    p_err_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> status[1]);
    p_irq_needs_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|status) && (|enable));
    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && err) |=> $stable(eaddr));
    p_held_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        held == status[1]);
    p_auto_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (srd && (|(sval & 8'h51)) && !done && !err) |=> status == 2'b00);
endmodule

bind irq_bank irq_bank_chk u_chk (
    .clk(clk_i), .rst_n(rst_ni), .done(done_i), .err(bus_err_i),
    .srd(dev_stat_rd_i), .sval(dev_stat_val_i),
    .status(status_q), .enable(enable_q), .held(cap_held),
    .eaddr(err_addr_q), .irq(irq_o)
);

// File: tb/irq_bank_test.sv
module irq_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  idx = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        done = 1'b0;
    logic        err = 1'b0;
    logic [63:0] eaddr = '0;
    logic        srd = 1'b0;
    logic [7:0]  sval = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_bank uut (
        .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_idx_i(idx),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .done_i(done),
        .bus_err_i(err), .bus_err_addr_i(eaddr), .dev_stat_rd_i(srd),
        .dev_stat_val_i(sval), .irq_o(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] i, output logic [31:0] v);
        @(negedge clk); idx = i; #1; v = rdata;
    endtask

    task automatic check_rd(string req, logic [2:0] i, logic [31:0] exp);
        logic [31:0] v;
        rd(i, v);
        check(req, v, exp);
    endtask

    task automatic wreg(logic [2:0] i, logic [31:0] d);
        @(negedge clk); wr = 1'b1; idx = i; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic pulse_err(logic [63:0] a);
        @(negedge clk); err = 1'b1; eaddr = a;
        @(negedge clk); err = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); done = 1'b1;
        @(negedge clk); done = 1'b0;
    endtask

    task automatic stat_read(logic [7:0] v);
        @(negedge clk); srd = 1'b1; sval = v;
        @(negedge clk); srd = 1'b0;
    endtask

    task automatic t_reset();
        check_rd("R1 status", 3'd3, 0);
        check_rd("R1 enable", 3'd5, 0);
        check_rd("R1 addr lo", 3'd0, 0);
        check_rd("R1 addr hi", 3'd1, 0);
        check("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_events();
        pulse_done();
        check_rd("R2 done sets bit0", 3'd3, 32'h1);
        check("R5 masked irq", {31'b0, irq}, 0);
        pulse_err(64'h1111_2222_3333_4444);
        check_rd("R2 err sets bit1", 3'd3, 32'h3);
        check_rd("R6 addr lo", 3'd0, 32'h3333_4444);
        check_rd("R6 addr hi", 3'd1, 32'h1111_2222);
    endtask

    task automatic t_hold();
        pulse_err(64'hAAAA_BBBB_CCCC_DDDD);
        check_rd("R7 addr lo held", 3'd0, 32'h3333_4444);
        check_rd("R7 addr hi held", 3'd1, 32'h1111_2222);
    endtask

    task automatic t_w1c();
        wreg(3'd3, 32'h0);
        check_rd("R3 zero write", 3'd3, 32'h3);
        wreg(3'd3, 32'h1);
        check_rd("R3 clear bit0", 3'd3, 32'h2);
        wreg(3'd3, 32'h2);
        check_rd("R3 clear bit1", 3'd3, 32'h0);
        pulse_err(64'h5555_6666_7777_8888);
        check_rd("R6 recapture lo", 3'd0, 32'h7777_8888);
        check_rd("R6 recapture hi", 3'd1, 32'h5555_6666);
    endtask

    task automatic t_enable();
        wreg(3'd5, 32'h3);
        check_rd("R4 set read5", 3'd5, 32'h3);
        check_rd("R4 set read7", 3'd7, 32'h3);
        check("R5 irq on err", {31'b0, irq}, 1);
        wreg(3'd7, 32'h2);
        check_rd("R4 clear bit1", 3'd5, 32'h1);
        check("R5 irq masked", {31'b0, irq}, 0);
        pulse_done();
        check("R5 irq on done", {31'b0, irq}, 1);
        wreg(3'd5, 32'h0);
        check_rd("R4 zero set", 3'd5, 32'h1);
        wreg(3'd7, 32'h0);
        check_rd("R4 zero clear", 3'd7, 32'h1);
    endtask

    task automatic t_auto();
        stat_read(8'h80);
        check_rd("R8 busy read no effect", 3'd3, 32'h3);
        stat_read(8'h40);
        check_rd("R8 idle read clears", 3'd3, 32'h0);
        check("R8 irq low", {31'b0, irq}, 0);
    endtask

    task automatic t_race();
        @(negedge clk); err = 1'b1; eaddr = 64'h0123_4567_89AB_CDEF;
        wr = 1'b1; idx = 3'd3; wdata = 32'h3;
        @(negedge clk); err = 1'b0; wr = 1'b0;
        check_rd("R9 err beats w1c", 3'd3, 32'h2);
        check_rd("R9 capture on race", 3'd0, 32'h89AB_CDEF);
        @(negedge clk); done = 1'b1; srd = 1'b1; sval = 8'h01;
        @(negedge clk); done = 1'b0; srd = 1'b0;
        check_rd("R9 done beats auto clear", 3'd3, 32'h1);
        pulse_err(64'h0000_0000_0000_0042);
        @(negedge clk); err = 1'b1; eaddr = 64'hFFFF_FFFF_FFFF_FFFF;
        wr = 1'b1; idx = 3'd3; wdata = 32'h2;
        @(negedge clk); err = 1'b0; wr = 1'b0;
        check_rd("R9 bit1 held on race", 3'd3, 32'h3);
        check_rd("R9 addr not reloaded", 3'd0, 32'h42);
        wreg(3'd3, 32'h3);
        pulse_err(64'h0000_0000_0000_0099);
        check_rd("R6 capture after release", 3'd0, 32'h99);
    endtask

    task automatic t_unmapped();
        wreg(3'd2, 32'hFFFF_FFFF);
        wreg(3'd4, 32'hFFFF_FFFF);
        wreg(3'd6, 32'hFFFF_FFFF);
        check_rd("R10 read idx2", 3'd2, 0);
        check_rd("R10 read idx4", 3'd4, 0);
        check_rd("R10 read idx6", 3'd6, 0);
        check_rd("R10 status kept", 3'd3, 32'h2);
        check_rd("R10 enable kept", 3'd5, 32'h1);
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_events();
        t_hold();
        t_w1c();
        t_enable();
        t_auto();
        t_race();
        t_unmapped();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule